// File: doc/BRIEF.md
# Smart Card Transmit Guard Timer

This block paces the interface side of a half-duplex smart card line. The interface sends characters to the card, and the card sends characters back. The block measures the time between the leading edges of start bits, counted in elementary time units (etus). It holds the transmit-permit output low until enough etus have passed since the last start edge. The send logic waits for permit before it launches the next character.

Two 8-bit guard values set the spacing, and each is a separate register.

- The character guard value applies when the interface sends two characters in a row.
- The block guard value applies when the card's character is followed by one from the interface.

The hardware adds an offset to each programmed value. The offset is 12 etus under T=0 and 11 etus under T=1. The protocol is taken from a NAK-enable input, which selects T=0 when high.

The inputs are a one-cycle-per-etu tick and one start strobe for each direction. Simple write strobes stand in for a register bus. If a guard register is rewritten while its own countdown runs, the countdown restarts from the new value.

Top module: `sc_guard_timer`

## Requirements
- R1: Right after reset, tx_permit is 1 and both guard readbacks are 0.
- R2: A write stores wr_data in the chosen guard register. Its 16-bit readback carries the value in bits 7:0, and bits 15:8 are zero.
- R3: With nak_en=1 (T=0), after a tx_start, tx_permit stays 0 for character guard + 11 etus and returns to 1 on tick number character guard + 12.
- R4: With nak_en=0 (T=1), after a tx_start, tx_permit returns to 1 on tick number character guard + 11 and not before.
- R5: After an rx_start, tx_permit returns to 1 on tick number block guard + 12 when nak_en=1, or block guard + 11 when nak_en=0.
- R6: A guard value of 0 gives the minimum spacing of 12 ticks (nak_en=1) or 11 ticks (nak_en=0).
- R7: Writing the guard register whose rule is counting reloads the count with the new value plus the offset. Writing the other register leaves the count unchanged. A write while the count is zero leaves tx_permit at 1.
- R8: A start strobe that arrives during a countdown restarts it under the rule of the new strobe.
- R9: The count steps down only on a cycle with etu_tick, and it stops at zero. Further ticks keep tx_permit at 1.
- R10: A start strobe in the same cycle as a write to its own guard register uses the value being written.
- R11: An etu_tick in the same cycle as a start strobe is not counted against the new spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| etu_tick | input | 1 | One-cycle pulse once per etu |
| tx_start | input | 1 | Start edge of an interface-to-card character |
| rx_start | input | 1 | Start edge of a card-to-interface character |
| nak_en | input | 1 | 1 selects T=0 (offset 12), 0 selects T=1 (offset 11) |
| chg_wr | input | 1 | Write strobe for the character guard register |
| blk_wr | input | 1 | Write strobe for the block guard register |
| wr_data | input | 8 | Write data for either guard register |
| chg_rdata | output | 16 | Character guard readback, upper byte zero |
| blk_rdata | output | 16 | Block guard readback, upper byte zero |
| tx_permit | output | 1 | High when the next transmit start is allowed |

## Verification
Some functions can land in the same cycle, and the bench covers each pair.

- **Start strobe and guard write.** The bench raises chg_wr and tx_start in one cycle. The spacing must follow the freshly written value (R10), so a stale value shows up as a permit edge that comes early or late.
- **Start strobe and tick.** The bench drives etu_tick together with tx_start. It then checks that a full span of ticks is still needed (R11).
- **Guard write and countdown.** The bench writes the running rule's register and, separately, the other register in the middle of a countdown. It counts the ticks to the permit edge in both cases (R7).

// File: rtl/sc_guard_pkg.sv
// Shared constants and types for the smart card transmit guard timer.
// Assumes offsets fixed by the line protocol: 12 etus for T=0, 11 for T=1.
package sc_guard_pkg;
    localparam int OFS_T0 = 12;
    localparam int OFS_T1 = 11;

    // Which spacing rule the running countdown was loaded under.
    typedef enum logic {
        RULE_CHAR  = 1'b0,
        RULE_BLOCK = 1'b1
    } rule_e;
endpackage

// File: rtl/sc_guard_regs.sv
// Holds the character and block guard registers written by plain strobes.
// Assumes at most one strobe per cycle matters per register; both may be written at once.
module sc_guard_regs #(
    parameter int GW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          chg_wr,
    input  logic          blk_wr,
    input  logic [GW-1:0] wr_data,
    output logic [GW-1:0] chg_q,
    output logic [GW-1:0] blk_q
);
    // Capture write data into the addressed guard register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chg_q <= '0;
            blk_q <= '0;
        end else begin
            if (chg_wr) chg_q <= wr_data;
            if (blk_wr) blk_q <= wr_data;
        end
    end
endmodule

// File: rtl/sc_guard_load.sv
// Decides when the guard counter is loaded and with what spacing.
// A transmit start loads the character rule, a receive start the block rule.
// A write to the register of the running rule reloads the count.
// Assumes tx_start and rx_start are not raised together; tx_start wins if they are.
module sc_guard_load
    import sc_guard_pkg::*;
#(
    parameter int GW = 8,
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_start,
    input  logic          rx_start,
    input  logic          chg_wr,
    input  logic          blk_wr,
    input  logic [GW-1:0] wr_data,
    input  logic [GW-1:0] chg_q,
    input  logic [GW-1:0] blk_q,
    input  logic          nak_en,
    input  logic          running,
    output logic          load,
    output logic [CW-1:0] load_val
);
    rule_e         rule_q, rule_d;
    logic [GW-1:0] chg_eff, blk_eff;
    logic [CW-1:0] ofs;

    // Same-cycle writes are seen by a start strobe.
    assign chg_eff = chg_wr ? wr_data : chg_q;
    assign blk_eff = blk_wr ? wr_data : blk_q;
    assign ofs     = nak_en ? CW'(OFS_T0) : CW'(OFS_T1);

    // Choose the load event, its value and the next rule.
    always_comb begin
        load     = 1'b0;
        load_val = '0;
        rule_d   = rule_q;
        if (tx_start) begin
            load     = 1'b1;
            load_val = CW'(chg_eff) + ofs;
            rule_d   = RULE_CHAR;
        end else if (rx_start) begin
            load     = 1'b1;
            load_val = CW'(blk_eff) + ofs;
            rule_d   = RULE_BLOCK;
        end else if (running && chg_wr && rule_q == RULE_CHAR) begin
            load     = 1'b1;
            load_val = CW'(wr_data) + ofs;
        end else if (running && blk_wr && rule_q == RULE_BLOCK) begin
            load     = 1'b1;
            load_val = CW'(wr_data) + ofs;
        end
    end

    // Remember the rule of the last start strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) rule_q <= RULE_CHAR;
        else        rule_q <= rule_d;
    end

    // R6: every load is at least the minimum offset of 11 etus.
    a_r6_min_load: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> load_val >= CW'(OFS_T1));
    // R8: a receive start switches the rule to block spacing.
    a_r8_rx_rule: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_start && !tx_start) |=> rule_q == RULE_BLOCK);
endmodule

// File: rtl/sc_guard_cnt.sv
// Down-counter of remaining guard etus; steps once per etu tick and rests at zero.
// Assumes a load takes priority over a tick in the same cycle.
module sc_guard_cnt #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          tick,
    output logic [CW-1:0] cnt
);
    // Load, count down on tick, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt <= '0;
        else if (load)                 cnt <= load_val;
        else if (tick && cnt != '0)    cnt <= cnt - 1'b1;
    end

    // R9: without tick or load the count holds.
    a_r9_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !tick) |=> $stable(cnt));
    // R9: zero is sticky until the next load.
    a_r9_stop_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt == '0) |=> cnt == '0);
    // R11: a load always lands its value, even with a tick.
    a_r11_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));
endmodule

// File: rtl/sc_guard_timer.sv
// Top of the smart card transmit guard timer. It joins the guard registers,
// the load decision and the etu down-counter. tx_permit is high when the
// remaining spacing count is zero.
// Assumes etu_tick is a single-cycle pulse per etu, from an external divider.
module sc_guard_timer
    import sc_guard_pkg::*;
#(
    parameter int GW  = 8,
    parameter int RDW = 16
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           etu_tick,
    input  logic           tx_start,
    input  logic           rx_start,
    input  logic           nak_en,
    input  logic           chg_wr,
    input  logic           blk_wr,
    input  logic [GW-1:0]  wr_data,
    output logic [RDW-1:0] chg_rdata,
    output logic [RDW-1:0] blk_rdata,
    output logic           tx_permit
);
    localparam int CW  = $clog2((2 ** GW) + OFS_T0);
    localparam int MAXC = (2 ** GW) - 1 + OFS_T0;

    logic [GW-1:0] chg_q, blk_q;
    logic          load;
    logic [CW-1:0] load_val, cnt;

    sc_guard_regs #(.GW(GW)) u_regs (
        .clk(clk), .rst_n(rst_n), .chg_wr(chg_wr), .blk_wr(blk_wr),
        .wr_data(wr_data), .chg_q(chg_q), .blk_q(blk_q)
    );

    sc_guard_load #(.GW(GW), .CW(CW)) u_load (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .rx_start(rx_start),
        .chg_wr(chg_wr), .blk_wr(blk_wr), .wr_data(wr_data),
        .chg_q(chg_q), .blk_q(blk_q), .nak_en(nak_en),
        .running(cnt != '0), .load(load), .load_val(load_val)
    );

    sc_guard_cnt #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val),
        .tick(etu_tick), .cnt(cnt)
    );

    assign chg_rdata = RDW'(chg_q);
    assign blk_rdata = RDW'(blk_q);
    assign tx_permit = (cnt == '0);

    // R1: permit is high in the first cycle after reset.
    a_r1_reset_permit: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> tx_permit);
    // R3: a transmit start withdraws permit on the next cycle.
    a_r3_tx_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_permit);
    // R5: a receive start withdraws permit on the next cycle.
    a_r5_rx_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        rx_start |=> !tx_permit);
    // R2: readback upper bits are zero.
    a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        chg_rdata[RDW-1:GW] == '0 && blk_rdata[RDW-1:GW] == '0);
    // R7: the count never exceeds the largest programmable spacing.
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(MAXC));
endmodule

// File: tb/sc_guard_timer_tb.sv
module sc_guard_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        etu_tick = 1'b0, tx_start = 1'b0, rx_start = 1'b0;
    logic        nak_en = 1'b1, chg_wr = 1'b0, blk_wr = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [15:0] chg_rdata, blk_rdata;
    logic        tx_permit;
    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    sc_guard_timer u_dut (
        .clk(clk), .rst_n(rst_n), .etu_tick(etu_tick), .tx_start(tx_start),
        .rx_start(rx_start), .nak_en(nak_en), .chg_wr(chg_wr), .blk_wr(blk_wr),
        .wr_data(wr_data), .chg_rdata(chg_rdata), .blk_rdata(blk_rdata),
        .tx_permit(tx_permit)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            etu_tick = 1'b1; @(negedge clk);
            etu_tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic wr_chg(input logic [7:0] v);
        chg_wr = 1'b1; wr_data = v; @(negedge clk); chg_wr = 1'b0;
    endtask

    task automatic wr_blk(input logic [7:0] v);
        blk_wr = 1'b1; wr_data = v; @(negedge clk); blk_wr = 1'b0;
    endtask

    task automatic pulse_tx();
        tx_start = 1'b1; @(negedge clk); tx_start = 1'b0;
    endtask

    task automatic pulse_rx();
        rx_start = 1'b1; @(negedge clk); rx_start = 1'b0;
    endtask

    // Low after n-1 ticks, high after the n-th.
    task automatic span(input int n, input string tag);
        ticks(n - 1);
        chk({tag, " low before span"}, tx_permit, 0);
        ticks(1);
        chk({tag, " high at span"}, tx_permit, 1);
    endtask

    task automatic t_reset();
        chk("R1 permit", tx_permit, 1);
        chk("R1 chg readback", chg_rdata, 0);
        chk("R1 blk readback", blk_rdata, 0);
    endtask

    task automatic t_readback();
        wr_chg(8'hA5);
        wr_blk(8'h3C);
        chk("R2 chg readback", chg_rdata, 16'h00A5);
        chk("R2 blk readback", blk_rdata, 16'h003C);
        chk("R7 idle write keeps permit", tx_permit, 1);
    endtask

    task automatic t_char_t0();
        nak_en = 1'b1; wr_chg(8'd5);
        pulse_tx();
        span(17, "R3 T0 char");
    endtask

    task automatic t_char_t1();
        nak_en = 1'b0; wr_chg(8'd9);
        pulse_tx();
        span(20, "R4 T1 char");
    endtask

    task automatic t_block();
        nak_en = 1'b1; wr_blk(8'd4);
        pulse_rx();
        span(16, "R5 T0 block");
        nak_en = 1'b0;
        pulse_rx();
        span(15, "R5 T1 block");
    endtask

    task automatic t_min();
        nak_en = 1'b1; wr_chg(8'd0);
        pulse_tx();
        span(12, "R6 T0 min");
        nak_en = 1'b0;
        pulse_tx();
        span(11, "R6 T1 min");
    endtask

    task automatic t_reload();
        nak_en = 1'b1; wr_chg(8'd20);
        pulse_tx();
        ticks(5);
        wr_chg(8'd3);
        span(15, "R7 reload same rule");
        pulse_tx();
        ticks(5);
        wr_blk(8'd100);
        span(10, "R7 other reg no effect");
    endtask

    task automatic t_restart();
        nak_en = 1'b1; wr_chg(8'd5); wr_blk(8'd2);
        pulse_tx();
        ticks(4);
        pulse_rx();
        span(14, "R8 restart block");
        pulse_rx();
        ticks(3);
        pulse_tx();
        span(17, "R8 restart char");
    endtask

    task automatic t_stop_zero();
        nak_en = 1'b0; wr_chg(8'd1);
        pulse_tx();
        repeat (30) @(negedge clk);
        chk("R9 no tick no count", tx_permit, 0);
        span(12, "R9 count");
        ticks(3);
        chk("R9 stays at zero", tx_permit, 1);
    endtask

    task automatic t_same_cycle_wr();
        nak_en = 1'b0; wr_chg(8'd40);
        chg_wr = 1'b1; wr_data = 8'd7; tx_start = 1'b1;
        @(negedge clk);
        chg_wr = 1'b0; tx_start = 1'b0;
        span(18, "R10 write with start");
    endtask

    task automatic t_same_cycle_tick();
        nak_en = 1'b1; wr_chg(8'd2);
        tx_start = 1'b1; etu_tick = 1'b1;
        @(negedge clk);
        tx_start = 1'b0; etu_tick = 1'b0;
        span(14, "R11 tick with start");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_char_t0();
        t_char_t1();
        t_block();
        t_min();
        t_reload();
        t_restart();
        t_stop_zero();
        t_same_cycle_wr();
        t_same_cycle_tick();
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog actual=timeout expected=finish");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule